// File: doc/BRIEF.md
# Dual-Core Memory Write-Permission Gate

This block stands between two processor subsystems, a master side and a control side, and a set of on-chip RAM regions. It decides whether each access may go ahead. Each side has two requesters, a CPU port and a DMA port. Every port presents a request strobe, a write strobe, a prefetch indication, a word address and write data. Port index 0 is the master CPU, 1 the master DMA, 2 the control CPU and 3 the control DMA.

The storage has three kinds of region:
- eight shared segments, each of which belongs to one side according to a runtime ownership map;
- two fixed one-direction message buffers, one carrying data from the master side to the control side and the other the reverse;
- a single-word ownership register.

Every side may read every mapped region. Only the privileged side of a region may write it or prefetch from it. A blocked write or prefetch leaves all storage unchanged. It produces a one-cycle violation pulse on the requesting port, together with the offending address.

When several ports address the same region in one cycle, a fixed priority picks one of them and the others are told to wait. Region sizes and the data width are parameters. The defaults keep the arrays small; setting `SEG_AW` to 9 with `DW` = 32 gives the full 2 KB buffer and 2 KB segment size per region. Real 8 KB segments need a wider `SEG_AW`.

Top module: `xg_mem_gate`

## Requirements
- R1: The word address is {region[3:0], word[5:0]} with the default parameters. Regions 0 to 7 are shared segments, region 8 is the master-to-control buffer, region 9 is the control-to-master buffer, region 15 is the ownership register, and regions 10 to 14 are unmapped.
- R2: The ownership register resets to 0. Its bit i set to 1 gives segment i to the control side, and 0 gives it to the master side. A read of region 15 returns the map in the low 8 data bits with zeros above.
- R3: Only master-side ports (0, 1) may write the ownership register. A write from port 2 or 3 is blocked, flagged as a violation, and leaves the map unchanged.
- R4: Only ports 0 and 1 may write or prefetch region 8, and only ports 2 and 3 may write or prefetch region 9. Any port may do a plain read of either buffer. A blocked write leaves the buffer contents unchanged.
- R5: A shared segment can be written only by the ports of its owning side. A write from the other side is blocked and leaves the segment unchanged.
- R6: A prefetch (read with the prefetch bit set) from a non-privileged side is blocked. It gives a violation and no read data. A prefetch from the privileged side returns data like a read.
- R7: A granted access that is blocked raises viol_o of that port for exactly one cycle, in the cycle after the request. In that cycle viol_addr_o of the port holds the request address. After reset no violation is shown.
- R8: A granted, allowed read raises rvalid_o of that port for one cycle, in the cycle after the request, with the word on rdata_o. After reset rvalid_o is low.
- R9: Ports addressing the same region in the same cycle are served in the order 0, 1, 2, 3. Each losing port sees wait_o high in that same cycle and its access is not performed. Ports on different regions proceed together without waiting.
- R10: A read of an unmapped region returns zero with rvalid_o. A write or prefetch of an unmapped region is blocked and flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request strobe per port |
| we_i | input | 4 | Write strobe per port (0 means read) |
| pf_i | input | 4 | Prefetch indication per port, used with reads |
| addr_i | input | 4*AW (40) | Word address per port, port p at bits p*AW and up |
| wdata_i | input | 4*DW (128) | Write data per port |
| wait_o | output | 4 | Port lost arbitration this cycle and must hold its request |
| rvalid_o | output | 4 | Read data valid, one cycle after an accepted read |
| rdata_o | output | 4*DW (128) | Read data per port |
| viol_o | output | 4 | One-cycle pulse marking a blocked access |
| viol_addr_o | output | 4*AW (40) | Address of the blocked access, valid with viol_o |

## Verification
Single-port accesses are tried from every port against both message buffers, one shared segment before and after its owner changes, the ownership register and an unmapped region. This tells the sending side apart from the receiving side, the owner from the non-owner, and a plain read from a prefetch and from a write. After each blocked write, a read-back shows that the storage kept its earlier value. Concurrent patterns cover three ports on one buffer while a fourth uses another region, a waiting write behind a read, and two ports on separate regions. These separate the effect of the priority order from the effect of region independence.

// File: rtl/xg_pkg.sv
package xg_pkg;
   localparam int NPORT = 4;

   typedef enum logic {
      SIDE_MST = 1'b0,
      SIDE_CTL = 1'b1
   } side_e;

   function automatic side_e port_side(input int p);
      return (p >= 2) ? SIDE_CTL : SIDE_MST;
   endfunction
endpackage

// File: rtl/xg_arbiter.sv
module xg_arbiter
   import xg_pkg::*;
#(
   parameter int RW = 4
) (
   input  logic [NPORT-1:0] req_i,
   input  logic [RW-1:0]    reg_i [NPORT],
   output logic [NPORT-1:0] wait_o,
   output logic [NPORT-1:0] gnt_o
);
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      if (p == 0) begin : g_top
         assign wait_o[p] = 1'b0;
      end else begin : g_low
         logic blocked;
         always_comb begin
            blocked = 1'b0;
            for (int q = 0; q < p; q++) begin
               if (req_i[q] && (reg_i[q] == reg_i[p])) blocked = 1'b1;
            end
         end
         assign wait_o[p] = req_i[p] & blocked;
      end
      assign gnt_o[p] = req_i[p] & ~wait_o[p];
   end
endmodule

// File: rtl/xg_policy.sv
module xg_policy
   import xg_pkg::*;
#(
   parameter int    RW    = 4,
   parameter int    NSEG  = 8,
   parameter int    R_M2C = 8,
   parameter int    R_C2M = 9,
   parameter int    R_CFG = 15,
   parameter side_e PSIDE = SIDE_MST
) (
   input  logic [RW-1:0]   region_i,
   input  logic            we_i,
   input  logic            pf_i,
   input  logic [NSEG-1:0] own_i,
   output logic            ok_o
);
   logic            has_priv;
   side_e           priv_side;
   logic [NSEG-1:0] shifted;

   assign shifted = own_i >> region_i;

   always_comb begin
      has_priv  = 1'b1;
      priv_side = SIDE_MST;
      if (int'(region_i) < NSEG) begin
         priv_side = side_e'(shifted[0]);
      end else if (int'(region_i) == R_M2C) begin
         priv_side = SIDE_MST;
      end else if (int'(region_i) == R_C2M) begin
         priv_side = SIDE_CTL;
      end else if (int'(region_i) == R_CFG) begin
         priv_side = SIDE_MST;
      end else begin
         has_priv = 1'b0;
      end
   end

   // plain reads always pass; writes and prefetches need privilege
   assign ok_o = (we_i || pf_i) ? (has_priv && (priv_side == PSIDE)) : 1'b1;
endmodule

// File: rtl/xg_bank.sv
module xg_bank #(
   parameter int DW = 32,
   parameter int AW = 6
) (
   input  logic          clk_i,
   input  logic          en_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (en_i) begin
         if (we_i) mem[addr_i] <= wdata_i;
         else      rdata_o     <= mem[addr_i];
      end
   end
endmodule

// File: rtl/xg_mem_gate.sv
module xg_mem_gate
   import xg_pkg::*;
#(
   parameter  int DW     = 32,
   parameter  int SEG_AW = 6,
   parameter  int NSEG   = 8,
   localparam int RW     = $clog2(NSEG + 3),
   localparam int AW     = RW + SEG_AW
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NPORT-1:0]  req_i,
   input  logic [NPORT-1:0]  we_i,
   input  logic [NPORT-1:0]  pf_i,
   input  logic [4*AW-1:0]   addr_i,
   input  logic [4*DW-1:0]   wdata_i,
   output logic [NPORT-1:0]  wait_o,
   output logic [NPORT-1:0]  rvalid_o,
   output logic [4*DW-1:0]   rdata_o,
   output logic [NPORT-1:0]  viol_o,
   output logic [4*AW-1:0]   viol_addr_o
);
   localparam int R_M2C = NSEG;
   localparam int R_C2M = NSEG + 1;
   localparam int R_CFG = (1 << RW) - 1;
   localparam int NBANK = NSEG + 2;

   initial begin
      assert (NSEG >= 1 && NSEG <= DW) else $error("NSEG must be 1..DW");
      assert (SEG_AW >= 1) else $error("SEG_AW must be at least 1");
      assert (R_CFG > R_C2M) else $error("region field too narrow");
   end

   logic [AW-1:0]     a      [NPORT];
   logic [RW-1:0]     rg     [NPORT];
   logic [DW-1:0]     wd     [NPORT];
   logic [NPORT-1:0]  gnt, ok, fire_wr, fire_rd, blk;
   logic [NSEG-1:0]   own_q, cfg_rd_q;
   logic [DW-1:0]     bank_q [NBANK];
   logic [RW-1:0]     rsel_q [NPORT];
   logic [NPORT-1:0]  rv_q, viol_q;
   logic [AW-1:0]     vaddr_q [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_unpack
      assign a[p]  = addr_i[p*AW +: AW];
      assign rg[p] = a[p][AW-1 -: RW];
      assign wd[p] = wdata_i[p*DW +: DW];
   end

   xg_arbiter #(.RW(RW)) u_arb (
      .req_i (req_i),
      .reg_i (rg),
      .wait_o(wait_o),
      .gnt_o (gnt)
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_pol
      xg_policy #(
         .RW(RW), .NSEG(NSEG), .R_M2C(R_M2C), .R_C2M(R_C2M), .R_CFG(R_CFG),
         .PSIDE(port_side(p))
      ) u_pol (
         .region_i(rg[p]),
         .we_i    (we_i[p]),
         .pf_i    (pf_i[p]),
         .own_i   (own_q),
         .ok_o    (ok[p])
      );
      assign fire_wr[p] = gnt[p] &  we_i[p] & ok[p];
      assign fire_rd[p] = gnt[p] & ~we_i[p] & ok[p];
      assign blk[p]     = gnt[p] & ~ok[p];
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic              en, we;
      logic [SEG_AW-1:0] ad;
      logic [DW-1:0]     dt;
      always_comb begin
         en = 1'b0;
         we = 1'b0;
         ad = '0;
         dt = '0;
         for (int p = 0; p < NPORT; p++) begin
            if ((fire_wr[p] || fire_rd[p]) && (rg[p] == RW'(b))) begin
               en = 1'b1;
               we = we_i[p];
               ad = a[p][SEG_AW-1:0];
               dt = wd[p];
            end
         end
      end
      xg_bank #(.DW(DW), .AW(SEG_AW)) u_mem (
         .clk_i  (clk_i),
         .en_i   (en),
         .we_i   (we),
         .addr_i (ad),
         .wdata_i(dt),
         .rdata_o(bank_q[b])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         own_q    <= '0;
         cfg_rd_q <= '0;
      end else begin
         for (int p = 0; p < NPORT; p++) begin
            if (rg[p] == RW'(R_CFG)) begin
               if (fire_wr[p]) own_q    <= wd[p][NSEG-1:0];
               if (fire_rd[p]) cfg_rd_q <= own_q;
            end
         end
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_out
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rv_q[p]    <= 1'b0;
            viol_q[p]  <= 1'b0;
            rsel_q[p]  <= '0;
            vaddr_q[p] <= '0;
         end else begin
            rv_q[p]   <= fire_rd[p];
            viol_q[p] <= blk[p];
            if (fire_rd[p]) rsel_q[p]  <= rg[p];
            if (blk[p])     vaddr_q[p] <= a[p];
         end
      end

      logic [DW-1:0] rd;
      always_comb begin
         rd = '0;
         if (int'(rsel_q[p]) < NBANK)       rd = bank_q[rsel_q[p]];
         else if (rsel_q[p] == RW'(R_CFG)) rd = DW'(cfg_rd_q);
      end

      assign rvalid_o[p]              = rv_q[p];
      assign viol_o[p]                = viol_q[p];
      assign rdata_o[p*DW +: DW]      = rd;
      assign viol_addr_o[p*AW +: AW]  = vaddr_q[p];
   end
endmodule

// File: rtl/xg_mem_gate_chk.sv
module xg_mem_gate_chk #(
   parameter int AW    = 10,
   parameter int RW    = 4,
   parameter int R_M2C = 8,
   parameter int R_CFG = 15
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [3:0]      req_i,
   input logic [3:0]      we_i,
   input logic [3:0]      pf_i,
   input logic [4*AW-1:0] addr_i,
   input logic [3:0]      wait_o,
   input logic [3:0]      rvalid_o,
   input logic [3:0]      viol_o,
   input logic [4*AW-1:0] viol_addr_o
);
   AST_MCPU_NEVER_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[0] |-> !wait_o[0]); // R9

   AST_SENDER_WRITE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[0] && we_i[0] && addr_i[AW-1 -: RW] == RW'(R_M2C)) |=> !viol_o[0]); // R4

   AST_CTL_CFG_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[2] && !wait_o[2] && we_i[2] && addr_i[2*AW+AW-1 -: RW] == RW'(R_CFG))
      |=> viol_o[2]); // R3

   for (genvar p = 0; p < 4; p++) begin : g_p
      AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rvalid_o[p] |-> $past(req_i[p] && !wait_o[p] && !we_i[p])); // R8

      AST_VIOL_AFTER_WR_OR_PF: assert property (@(posedge clk_i) disable iff (!rst_ni)
         viol_o[p] |-> $past(req_i[p] && !wait_o[p] && (we_i[p] || pf_i[p]))); // R7

      AST_VIOL_ADDR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
         viol_o[p] |-> (viol_addr_o[p*AW +: AW] == $past(addr_i[p*AW +: AW]))); // R7

      AST_NO_DATA_WITH_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(rvalid_o[p] && viol_o[p])); // R6

      if (p > 0) begin : g_low
         AST_WAIT_HAS_RIVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wait_o[p] |-> (req_i[p] && |(req_i & 4'((1 << p) - 1)))); // R9
      end
   end
endmodule

bind xg_mem_gate xg_mem_gate_chk #(
   .AW(AW), .RW(RW), .R_M2C(R_M2C), .R_CFG(R_CFG)
) u_chk (.*);

// File: tb/sim_xg_mem_gate.sv
module sim_xg_mem_gate;
   localparam int AW = 10;
   localparam int DW = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [3:0]     req = '0, we = '0, pf = '0;
   logic [4*AW-1:0] addr = '0;
   logic [4*DW-1:0] wdata = '0;
   logic [3:0]     wait_o, rvalid_o, viol_o;
   logic [4*DW-1:0] rdata_o;
   logic [4*AW-1:0] viol_addr_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   xg_mem_gate u0 (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .pf_i(pf),
      .addr_i(addr), .wdata_i(wdata), .wait_o(wait_o), .rvalid_o(rvalid_o),
      .rdata_o(rdata_o), .viol_o(viol_o), .viol_addr_o(viol_addr_o)
   );

   typedef struct packed {
      logic [1:0]  port;
      logic        w;
      logic        f;
      logic [9:0]  a;
      logic [31:0] d;
      logic        ev;
      logic        er;
      logic [31:0] ed;
      logic [3:0]  rq;
   } vec_t;

   // address = region*64 + word; M2C=0x200, C2M=0x240, CFG=0x3C0, seg2=0x080
   localparam vec_t VEC [24] = '{
      '{2'd0,1'b1,1'b0,10'h203,32'h0000_00A1,1'b0,1'b0,32'h0,4'd4},   // R4
      '{2'd2,1'b0,1'b0,10'h203,32'h0,1'b0,1'b1,32'h0000_00A1,4'd8},    // R8
      '{2'd2,1'b1,1'b0,10'h203,32'h0000_0BAD,1'b1,1'b0,32'h0,4'd4},    // R4
      '{2'd3,1'b0,1'b0,10'h203,32'h0,1'b0,1'b1,32'h0000_00A1,4'd4},    // R4
      '{2'd2,1'b0,1'b1,10'h203,32'h0,1'b1,1'b0,32'h0,4'd6},            // R6
      '{2'd3,1'b1,1'b0,10'h245,32'h0000_00C5,1'b0,1'b0,32'h0,4'd4},    // R4
      '{2'd1,1'b1,1'b0,10'h245,32'h0000_0BAD,1'b1,1'b0,32'h0,4'd4},    // R4
      '{2'd0,1'b0,1'b0,10'h245,32'h0,1'b0,1'b1,32'h0000_00C5,4'd4},    // R4
      '{2'd1,1'b1,1'b0,10'h085,32'h0000_00D2,1'b0,1'b0,32'h0,4'd5},    // R5
      '{2'd2,1'b1,1'b0,10'h085,32'h0000_0BAD,1'b1,1'b0,32'h0,4'd5},    // R5
      '{2'd3,1'b0,1'b0,10'h085,32'h0,1'b0,1'b1,32'h0000_00D2,4'd5},    // R5
      '{2'd3,1'b0,1'b1,10'h085,32'h0,1'b1,1'b0,32'h0,4'd6},            // R6
      '{2'd0,1'b0,1'b1,10'h085,32'h0,1'b0,1'b1,32'h0000_00D2,4'd6},    // R6
      '{2'd2,1'b1,1'b0,10'h3C0,32'h0000_00FF,1'b1,1'b0,32'h0,4'd3},    // R3
      '{2'd0,1'b0,1'b0,10'h3C0,32'h0,1'b0,1'b1,32'h0,4'd3},            // R3
      '{2'd1,1'b1,1'b0,10'h3C0,32'h0000_0004,1'b0,1'b0,32'h0,4'd2},    // R2
      '{2'd0,1'b0,1'b0,10'h3C0,32'h0,1'b0,1'b1,32'h0000_0004,4'd2},    // R2
      '{2'd2,1'b1,1'b0,10'h085,32'h0000_00E2,1'b0,1'b0,32'h0,4'd5},    // R5
      '{2'd0,1'b1,1'b0,10'h085,32'h0000_0BAD,1'b1,1'b0,32'h0,4'd5},    // R5
      '{2'd1,1'b0,1'b0,10'h085,32'h0,1'b0,1'b1,32'h0000_00E2,4'd5},    // R5
      '{2'd2,1'b0,1'b1,10'h085,32'h0,1'b0,1'b1,32'h0000_00E2,4'd6},    // R6
      '{2'd1,1'b0,1'b1,10'h085,32'h0,1'b1,1'b0,32'h0,4'd6},            // R6
      '{2'd0,1'b1,1'b0,10'h285,32'h0000_0BAD,1'b1,1'b0,32'h0,4'd10},   // R10
      '{2'd3,1'b0,1'b0,10'h285,32'h0,1'b0,1'b1,32'h0,4'd10}            // R10
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input int p, input bit w, input bit f, input logic [9:0] a, input logic [31:0] d);
      req[p] = 1'b1; we[p] = w; pf[p] = f;
      addr[p*AW +: AW] = a; wdata[p*DW +: DW] = d;
   endtask

   task automatic idle();
      req = '0; we = '0; pf = '0;
   endtask

   task automatic access(input vec_t v);
      string tag;
      int p;
      tag = $sformatf("R%0d", v.rq);
      p = int'(v.port);
      @(negedge clk); drive(p, v.w, v.f, v.a, v.d);
      @(negedge clk); idle();
      chk(viol_o[p] == v.ev, {tag, " viol"}, 64'(viol_o[p]), 64'(v.ev));
      chk(rvalid_o[p] == v.er, {tag, " rvalid"}, 64'(rvalid_o[p]), 64'(v.er));
      if (v.er) chk(rdata_o[p*DW +: DW] == v.ed, {tag, " rdata"}, 64'(rdata_o[p*DW +: DW]), 64'(v.ed));
      if (v.ev) chk(viol_addr_o[p*AW +: AW] == v.a, "R7 viol addr", 64'(viol_addr_o[p*AW +: AW]), 64'(v.a));
      @(negedge clk);
      chk(viol_o == 4'b0 && rvalid_o == 4'b0, "R7 one-cycle pulse", 64'({viol_o, rvalid_o}), 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state: no wait, no read data, no violation (R7, R8)
      chk(wait_o == 4'b0, "R9 reset wait", 64'(wait_o), 64'h0);
      chk(rvalid_o == 4'b0, "R8 reset rvalid", 64'(rvalid_o), 64'h0);
      chk(viol_o == 4'b0, "R7 reset viol", 64'(viol_o), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 24; i++) access(VEC[i]);

      // R9: three ports on region 8, port 3 on region 9
      @(negedge clk);
      drive(0, 0, 0, 10'h203, 0); drive(1, 0, 0, 10'h203, 0);
      drive(2, 0, 0, 10'h203, 0); drive(3, 0, 0, 10'h245, 0);
      #1 chk(wait_o == 4'b0110, "R9 wait pattern", 64'(wait_o), 64'h6);
      @(negedge clk);
      chk(rvalid_o == 4'b1001, "R9 first winners", 64'(rvalid_o), 64'h9);
      chk(rdata_o[31:0] == 32'hA1, "R9 port0 data", 64'(rdata_o[31:0]), 64'hA1);
      chk(rdata_o[127:96] == 32'hC5, "R9 port3 data", 64'(rdata_o[127:96]), 64'hC5);
      req[0] = 1'b0; req[3] = 1'b0;
      #1 chk(wait_o == 4'b0100, "R9 second round wait", 64'(wait_o), 64'h4);
      @(negedge clk);
      chk(rvalid_o == 4'b0010, "R9 second winner", 64'(rvalid_o), 64'h2);
      chk(rdata_o[63:32] == 32'hA1, "R9 port1 data", 64'(rdata_o[63:32]), 64'hA1);
      req[1] = 1'b0;
      @(negedge clk);
      chk(rvalid_o == 4'b0100, "R9 last winner", 64'(rvalid_o), 64'h4);
      idle();

      // R9: a waiting write is not performed
      @(negedge clk);
      drive(0, 0, 0, 10'h203, 0); drive(2, 1, 0, 10'h203, 32'hBAD);
      #1 chk(wait_o[2] == 1'b1, "R9 loser waits", 64'(wait_o), 64'h4);
      @(negedge clk); idle();
      chk(viol_o[2] == 1'b0, "R9 loser not flagged", 64'(viol_o), 64'h0);
      access('{2'd3, 1'b0, 1'b0, 10'h203, 32'h0, 1'b0, 1'b1, 32'hA1, 4'd9});

      // R9: different regions proceed together
      @(negedge clk);
      drive(0, 1, 0, 10'h041, 32'h11); drive(3, 1, 0, 10'h246, 32'h33);
      #1 chk(wait_o == 4'b0, "R9 no wait across regions", 64'(wait_o), 64'h0);
      @(negedge clk); idle();
      access('{2'd1, 1'b0, 1'b0, 10'h041, 32'h0, 1'b0, 1'b1, 32'h11, 4'd9});
      access('{2'd2, 1'b0, 1'b0, 10'h246, 32'h0, 1'b0, 1'b1, 32'h33, 4'd9});

      // R1: region 7 is a shared segment owned by master after the map write above
      access('{2'd0, 1'b1, 1'b0, 10'h1C2, 32'h77, 1'b0, 1'b0, 32'h0, 4'd1});
      access('{2'd3, 1'b0, 1'b0, 10'h1C2, 32'h0, 1'b0, 1'b1, 32'h77, 4'd1});

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule